// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes one idle-high asynchronous serial line and turns each frame on it into a byte in a readable data register. The line is synchronised, oversampled by an external tick, and checked for a valid start bit. The receiver then samples each data bit at its centre, followed by an optional parity bit and one or two stop bits. A separate shift register collects the bits, so the data register only changes when a frame completes.

Status is held in four flags: data available, overrun, parity error and framing error. A host reads the byte with a read strobe, which also clears the data-available flag. It clears each error flag with its own strobe. Two level interrupt requests, one for a completed receive and one for any error, are formed from these flags and a single enable.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the data register is 0x00, all four flags are 0 and both interrupt requests are 0.
- R2: On an oversampling tick the receiver starts a frame only if the line is low, and it checks the line again seven ticks later. If the line has gone high by then, it returns to idle and no byte or flag changes.
- R3: Data bits arrive LSB first. With the 8-bit setting all 8 bits are stored. With the 7-bit setting, 7 bits are stored in data[6:0] and data[7] reads 0.
- R4: With parity enabled, the data bits plus the parity bit must hold an even number of ones (even mode) or an odd number (odd mode). A mismatch sets the parity-error flag and still stores the byte, but the data-available flag is not set.
- R5: A 0 in the first stop bit sets the framing-error flag and still stores the byte, without setting data-available. With two stop bits, the second one is not checked.
- R6: A frame with no parity or framing error stores its byte and sets the data-available flag.
- R7: If a frame completes while data-available is 1 and no read strobe is present in that cycle, the overrun flag is set. The data register keeps its old value and the new byte is dropped.
- R8: The read strobe clears data-available. If the byte is read before the next frame completes, that frame is stored with no overrun.
- R9: Each error flag stays set until its own clear strobe. The read strobe does not clear error flags.
- R10: The receive interrupt is 1 when the enable and data-available are both 1. The error interrupt is 1 when the enable is 1 and any error flag is 1. With the enable at 0, both are 0.
- R11: Data length, parity enable, parity mode and stop-bit count are captured when the start bit is detected. Changes made during a frame do not affect that frame.
- R12: After a frame ends, a new start bit is accepted only once the line has been seen high on a tick. A stop bit held low therefore does not start a false frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_eight | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_irq_en | input | 1 | Enable for both interrupt requests |
| rd_stb | input | 1 | Read of the data register; clears data-available |
| clr_ovr | input | 1 | Clears the overrun flag |
| clr_par | input | 1 | Clears the parity-error flag |
| clr_frm | input | 1 | Clears the framing-error flag |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Data-available flag |
| ovr_flag | output | 1 | Overrun flag |
| par_flag | output | 1 | Parity-error flag |
| frm_flag | output | 1 | Framing-error flag |
| irq_rx | output | 1 | Receive-complete interrupt request (level) |
| irq_err | output | 1 | Receive-error interrupt request (level) |

## Verification
The bench targets the cases where the error paths diverge. It sends a second frame with no read in between; a receiver that overwrote on overrun would show the new byte. It sends frames with bad parity and a low stop bit; a receiver that dropped the byte would keep stale data, and one that set data-available would raise the wrong interrupt. It drives a low second stop bit and a low first stop bit followed by a clean frame, which catches a receiver that checks both stop bits or re-triggers on a held-low line. It also applies a short line glitch, reads the data register while the next frame is still shifting in, and changes the configuration mid-frame; these expose start validation that is missing, a false overrun, and settings that are not latched.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int RX_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic [RX_DATA_W-1:0] data;
        logic                 par_err;
        logic                 frm_err;
    } frame_res_t;

    // Parity fails when the total count of ones disagrees with the mode.
    function automatic logic parity_bad(input logic [RX_DATA_W-1:0] d,
                                        input logic pbit,
                                        input logic odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  frame_cfg_t cfg,
    output logic       done,
    output frame_res_t res
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(RX_DATA_W);
    localparam logic [CW-1:0] HALF_M1 = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

    rx_state_e             state;
    logic [CW-1:0]         cnt;
    logic [IW-1:0]         bit_idx;
    logic [RX_DATA_W-1:0]  shreg;
    frame_cfg_t            cfg_q;
    logic                  pbit_q;
    logic                  frm_q;
    logic                  armed;

    logic                  at_mid;
    logic [IW-1:0]         last_idx;
    logic [RX_DATA_W-1:0]  aligned;
    frame_res_t            fin_res;

    always_comb begin
        at_mid   = (cnt == FULL_M1);
        last_idx = cfg_q.eight ? IW'(RX_DATA_W - 1) : IW'(RX_DATA_W - 2);
        aligned  = cfg_q.eight ? shreg : {1'b0, shreg[RX_DATA_W-1:1]};
        fin_res.data    = aligned;
        fin_res.par_err = cfg_q.par_en && parity_bad(aligned, pbit_q, cfg_q.par_odd);
        fin_res.frm_err = (state == ST_STOP1) ? !line : frm_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            cfg_q   <= '0;
            pbit_q  <= 1'b0;
            frm_q   <= 1'b0;
            armed   <= 1'b0;
            done    <= 1'b0;
            res     <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line && armed) begin
                            state <= ST_START;
                            cnt   <= CW'(1);
                            cfg_q <= cfg;
                            armed <= 1'b0;
                        end else begin
                            armed <= line;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF_M1) begin
                            cnt <= '0;
                            if (!line) begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_mid) begin
                            cnt     <= '0;
                            shreg   <= {line, shreg[RX_DATA_W-1:1]};
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == last_idx)
                                state <= cfg_q.par_en ? ST_PAR : ST_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_mid) begin
                            cnt    <= '0;
                            pbit_q <= line;
                            state  <= ST_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP1: begin
                        if (at_mid) begin
                            cnt   <= '0;
                            frm_q <= !line;
                            if (cfg_q.two_stop) begin
                                state <= ST_STOP2;
                            end else begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                                res   <= fin_res;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (at_mid) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            res   <= fin_res;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done,
    input  frame_res_t           res,
    input  logic                 rd_stb,
    input  logic                 clr_ovr,
    input  logic                 clr_par,
    input  logic                 clr_frm,
    input  logic                 irq_en,
    output logic [RX_DATA_W-1:0] data_q,
    output logic                 full_q,
    output logic                 ovr_q,
    output logic                 par_q,
    output logic                 frm_q,
    output logic                 irq_rx,
    output logic                 irq_err
);
    logic occupied;
    assign occupied = full_q && !rd_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
        end else begin
            if (rd_stb)  full_q <= 1'b0;
            if (clr_ovr) ovr_q  <= 1'b0;
            if (clr_par) par_q  <= 1'b0;
            if (clr_frm) frm_q  <= 1'b0;
            if (done) begin
                if (occupied) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q <= res.data;
                    if (res.par_err) par_q <= 1'b1;
                    if (res.frm_err) frm_q <= 1'b1;
                    if (!res.par_err && !res.frm_err) full_q <= 1'b1;
                end
            end
        end
    end

    assign irq_rx  = irq_en & full_q;
    assign irq_err = irq_en & (ovr_q | par_q | frm_q);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_in,
    input  logic                 os_tick,
    input  logic                 cfg_eight,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic                 cfg_two_stop,
    input  logic                 cfg_irq_en,
    input  logic                 rd_stb,
    input  logic                 clr_ovr,
    input  logic                 clr_par,
    input  logic                 clr_frm,
    output logic [RX_DATA_W-1:0] rx_data,
    output logic                 rx_full,
    output logic                 ovr_flag,
    output logic                 par_flag,
    output logic                 frm_flag,
    output logic                 irq_rx,
    output logic                 irq_err
);
    logic       line_s;
    logic       frame_done;
    frame_res_t frame_res;
    frame_cfg_t cfg_now;

    assign cfg_now = '{eight: cfg_eight, par_en: cfg_par_en,
                       par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (line_in),
        .dout (line_s)
    );

    srx_framer #(.OSR(OSR)) u_framer (
        .clk  (clk),
        .rst  (rst),
        .tick (os_tick),
        .line (line_s),
        .cfg  (cfg_now),
        .done (frame_done),
        .res  (frame_res)
    );

    srx_status u_status (
        .clk     (clk),
        .rst     (rst),
        .done    (frame_done),
        .res     (frame_res),
        .rd_stb  (rd_stb),
        .clr_ovr (clr_ovr),
        .clr_par (clr_par),
        .clr_frm (clr_frm),
        .irq_en  (cfg_irq_en),
        .data_q  (rx_data),
        .full_q  (rx_full),
        .ovr_q   (ovr_flag),
        .par_q   (par_flag),
        .frm_q   (frm_flag),
        .irq_rx  (irq_rx),
        .irq_err (irq_err)
    );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_stb,
    input logic       clr_par,
    input logic       clr_frm,
    input logic       cfg_irq_en,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       ovr_flag,
    input logic       par_flag,
    input logic       frm_flag,
    input logic       irq_rx,
    input logic       irq_err,
    input logic       done
);
    a_r7_ovr_keeps_data: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $stable(rx_data));

    a_r8_read_clears_full: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !done) |=> !rx_full);

    a_r9_par_sticky: assert property (@(posedge clk) disable iff (rst)
        (par_flag && !clr_par) |=> par_flag);

    a_r9_frm_sticky: assert property (@(posedge clk) disable iff (rst)
        (frm_flag && !clr_frm) |=> frm_flag);

    a_r10_rx_irq_needs_full: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> rx_full);

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
        !cfg_irq_en |-> !(irq_rx || irq_err));

    a_r10_err_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> (ovr_flag || par_flag || frm_flag));

    a_r6_full_after_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(done));

    a_r4_par_after_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(par_flag) |-> $past(done));

    a_r5_frm_after_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(frm_flag) |-> $past(done));
endmodule

bind serial_rx_core serial_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_stb     (rd_stb),
    .clr_par    (clr_par),
    .clr_frm    (clr_frm),
    .cfg_irq_en (cfg_irq_en),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .ovr_flag   (ovr_flag),
    .par_flag   (par_flag),
    .frm_flag   (frm_flag),
    .irq_rx     (irq_rx),
    .irq_err    (irq_err),
    .done       (frame_done)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_in = 1'b1;
    logic       os_tick = 1'b0;
    logic       cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       cfg_irq_en = 1'b1;
    logic       rd_stb = 1'b0, clr_ovr = 1'b0, clr_par = 1'b0, clr_frm = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, ovr_flag, par_flag, frm_flag, irq_rx, irq_err;

    int checks = 0;
    int failures = 0;
    int tdiv = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv    <= (tdiv + 1) % TICK_DIV;
        os_tick <= (tdiv == TICK_DIV - 1);
    end

    serial_rx_core u_dut (
        .clk(clk), .rst(rst), .line_in(line_in), .os_tick(os_tick),
        .cfg_eight(cfg_eight), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_irq_en(cfg_irq_en),
        .rd_stb(rd_stb), .clr_ovr(clr_ovr), .clr_par(clr_par), .clr_frm(clr_frm),
        .rx_data(rx_data), .rx_full(rx_full), .ovr_flag(ovr_flag),
        .par_flag(par_flag), .frm_flag(frm_flag), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    // reference model state
    logic [7:0] m_data = 8'h00;
    logic       m_full = 0, m_ovr = 0, m_par = 0, m_frm = 0;

    typedef struct {
        logic [7:0] data;
        logic full, ovr, par, frm, irx, ierr;
        string tag;
    } exp_t;
    exp_t sbq[$];
    event chk_ev;

    task automatic cmp(string tag, string fld, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
        end
    endtask

    initial begin
        forever begin
            exp_t e;
            @(chk_ev);
            e = sbq.pop_front();
            cmp(e.tag, "data", rx_data, e.data);
            cmp(e.tag, "full", {7'd0, rx_full}, {7'd0, e.full});
            cmp(e.tag, "ovr", {7'd0, ovr_flag}, {7'd0, e.ovr});
            cmp(e.tag, "par", {7'd0, par_flag}, {7'd0, e.par});
            cmp(e.tag, "frm", {7'd0, frm_flag}, {7'd0, e.frm});
            cmp(e.tag, "irq_rx (R10)", {7'd0, irq_rx}, {7'd0, e.irx});
            cmp(e.tag, "irq_err (R10)", {7'd0, irq_err}, {7'd0, e.ierr});
        end
    end

    task automatic push_expect(string tag);
        exp_t e;
        e.data = m_data; e.full = m_full; e.ovr = m_ovr; e.par = m_par; e.frm = m_frm;
        e.irx  = cfg_irq_en & m_full;
        e.ierr = cfg_irq_en & (m_ovr | m_par | m_frm);
        e.tag  = tag;
        sbq.push_back(e);
        ->chk_ev;
        @(negedge clk);
    endtask

    task automatic set_cfg(bit eight, bit pe, bit odd, bit two);
        cfg_eight = eight; cfg_par_en = pe; cfg_par_odd = odd; cfg_two_stop = two;
    endtask

    task automatic hold_bit(logic v);
        line_in = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic drive_frame(logic [7:0] d, bit eight, bit pe, bit odd, bit two,
                               bit bad_par, bit bad_s1, bit bad_s2);
        logic [7:0] dm;
        logic p;
        dm = eight ? d : {1'b0, d[6:0]};
        hold_bit(1'b0);
        for (int i = 0; i < (eight ? 8 : 7); i++) hold_bit(d[i]);
        if (pe) begin
            p = odd ? ~(^dm) : (^dm);
            hold_bit(bad_par ? ~p : p);
        end
        hold_bit(!bad_s1);
        if (two) hold_bit(!bad_s2);
        hold_bit(1'b1);
        if (m_full) begin
            m_ovr = 1;
        end else begin
            m_data = dm;
            if (pe && bad_par) m_par = 1;
            if (bad_s1) m_frm = 1;
            if (!(pe && bad_par) && !bad_s1) m_full = 1;
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic do_read(string tag);
        pulse(rd_stb); m_full = 0; push_expect(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        push_expect("R1 reset state");

        set_cfg(1, 0, 0, 0);
        drive_frame(8'hA5, 1, 0, 0, 0, 0, 0, 0);
        push_expect("R6 R3 clean 8-bit frame");
        do_read("R8 read clears full");

        set_cfg(1, 1, 0, 0);
        drive_frame(8'h3C, 1, 1, 0, 0, 0, 0, 0);
        push_expect("R4 even parity good");
        do_read("R8 read after parity frame");

        set_cfg(1, 1, 1, 0);
        drive_frame(8'h96, 1, 1, 1, 0, 1, 0, 0);
        push_expect("R4 odd parity error stores byte");
        do_read("R9 read leaves parity flag");
        pulse(clr_par); m_par = 0;
        push_expect("R9 parity flag cleared by strobe");

        set_cfg(0, 0, 0, 0);
        drive_frame(8'hD5, 0, 0, 0, 0, 0, 0, 0);
        push_expect("R3 seven-bit frame msb zero");
        do_read("R8 read seven-bit");

        set_cfg(1, 0, 0, 0);
        drive_frame(8'h0F, 1, 0, 0, 0, 0, 1, 0);
        push_expect("R5 low stop sets framing error");
        drive_frame(8'h81, 1, 0, 0, 0, 0, 0, 0);
        push_expect("R12 clean frame after held-low stop");
        do_read("R9 read leaves framing flag");
        pulse(clr_frm); m_frm = 0;
        push_expect("R9 framing flag cleared by strobe");

        set_cfg(1, 0, 0, 1);
        drive_frame(8'h5A, 1, 0, 0, 1, 0, 0, 1);
        push_expect("R5 second stop bit unchecked");

        set_cfg(1, 0, 0, 0);
        drive_frame(8'hC3, 1, 0, 0, 0, 0, 0, 0);
        push_expect("R7 overrun keeps old byte");
        pulse(clr_ovr); m_ovr = 0;
        do_read("R9 overrun cleared");

        drive_frame(8'h11, 1, 0, 0, 0, 0, 0, 0);
        push_expect("R6 first of back-to-back");
        fork
            drive_frame(8'h22, 1, 0, 0, 0, 0, 0, 0);
            begin
                repeat (4 * BIT_CLKS) @(negedge clk);
                pulse(rd_stb); m_full = 0;
            end
        join
        push_expect("R8 read during shift avoids overrun");
        do_read("R8 read second");

        line_in = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        line_in = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        push_expect("R2 short glitch ignored");
        drive_frame(8'h3E, 1, 0, 0, 0, 0, 0, 0);
        push_expect("R2 receiver idle after glitch");
        do_read("R8 read after glitch");

        cfg_irq_en = 1'b0;
        set_cfg(1, 1, 0, 0);
        drive_frame(8'h07, 1, 1, 0, 0, 1, 0, 0);
        push_expect("R10 interrupts masked with error");
        pulse(clr_par); m_par = 0;
        cfg_irq_en = 1'b1;
        push_expect("R10 enable back on");

        set_cfg(1, 0, 0, 0);
        fork
            drive_frame(8'hE7, 1, 0, 0, 0, 0, 0, 0);
            begin
                repeat (2 * BIT_CLKS) @(negedge clk);
                set_cfg(0, 1, 1, 1);
            end
        join
        set_cfg(1, 0, 0, 0);
        push_expect("R11 settings latched at start");
        do_read("R8 final read");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule